// File: doc/BRIEF.md
# Flow-Through Burst Static RAM

This block is a clock-synchronous static RAM with a flow-through read path. It is built over a small word array that is parameterised. Each word holds four byte lanes. Every lane has eight data bits and one parity bit. The address, the three chip selects and the write controls are captured on the rising clock edge. Read data comes straight out of the array, using the address captured at that same edge, so it appears within the cycle that follows the edge. No output register is added.

An access begins on one of two address strobes. The CPU-side strobe is gated by the primary select and always starts a read. The controller-side strobe starts a read or a write, depending on the write controls. After a burst has started, an advance input does one of two things when both strobes are idle. It steps a two-bit burst counter, in linear or interleaved order, or it holds the current address as a wait state. Writes can cover selected lanes or all lanes at once. An asynchronous output enable and a doze input keep the read bus undriven. The doze input also stops input sampling after a fixed two-edge latency.

Top module: `fbs_sram`

## Requirements
- R1: After synchronous reset, `d_out_en` is low and no burst is active: an edge with both strobes high drives nothing.
- R2: Lane i occupies `d_in`/`d_out` bits [9i+8:9i], with bit 9i+8 as the lane's parity bit. When `wr_all_n` is low, all four lanes are written. Otherwise, when `wr_byte_n` is low, exactly the lanes whose `lane_wr_n` bit is low are written, parity bit included.
- R3: When `wr_all_n` and `wr_byte_n` are both high, nothing is written, whatever `lane_wr_n` holds, and the cycle is a read.
- R4: Starting a burst needs `sel_n` low, `sel_hi` high and `sel_lo_n` low. With these, a low `strb_cpu_n` starts a read burst at `addr` and never writes. A write to that address is possible on the next edge by holding `step_n` high with a write requested.
- R5: `strb_cpu_n` has no effect while `sel_n` is high; the edge is decoded as if that strobe were high. A strobe sampled with `sel_n` low but a secondary select inactive gives a deselect.
- R6: If `strb_ctl_n` is low, `strb_cpu_n` is high or masked, and all selects are active, a burst starts at `addr`. The burst is a write when a write is requested, and a read otherwise.
- R7: If both strobes are high, `step_n` is low and a burst is active, the access moves to the next burst address. The two low address bits follow base+k (mod 4) when `seq_linear` is 1, and base XOR k when it is 0. The count k wraps after four, and the upper address bits do not change.
- R8: If both strobes are high, `step_n` is high and a burst is active, the current address is used again, for a read or a write.
- R9: A read started at an edge presents the addressed word on `d_out` after that edge and before the next one.
- R10: `d_out_en` is low after a deselect or write edge, and while `out_en_n` or `doze` is high. `d_out` is all zeros whenever `d_out_en` is low.
- R11: If `doze` is first sampled high at edge k, edges k and k+1 are still decoded, and from edge k+2 on every edge acts as a deselect with no write. If `doze` is first sampled low at edge m, edges m and m+1 are still ignored, and sampling resumes at edge m+2.
- R12: A deselect ends the burst. A step or hold edge that arrives with no burst active is a deselect and drives nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW | Word address, sampled when a burst starts |
| sel_n | input | 1 | Primary chip select, active low; masks the CPU strobe |
| sel_hi | input | 1 | Secondary chip select, active high |
| sel_lo_n | input | 1 | Secondary chip select, active low |
| strb_cpu_n | input | 1 | CPU-side address strobe, active low, read only |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| step_n | input | 1 | Burst advance, active low; high holds the address |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_byte_n | input | 1 | Enable for the per-lane write strobes, active low |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| doze | input | 1 | Sleep request, active high |
| seq_linear | input | 1 | Burst order: 1 linear, 0 interleaved; held static |
| d_in | input | DW | Write data, four 9-bit lanes |
| d_out | output | DW | Read data, zero when not driven |
| d_out_en | output | 1 | High when the read bus is driven |

## Verification
The bench runs bursts that start on a non-zero low address, in both orders, and carries them past the fourth beat. A counter that saturates, or that mixes up add and XOR, returns the wrong word on a beat. It writes a word in the cycle after a CPU-side start and does partial lane writes that include parity. It also tries a write with lane strobes low but the byte enable high, so a faulty mask computation corrupts lanes that should be untouched. Masked strobes, selects missing at strobe time, and step cycles after a deselect are all tried; a decoder that gave the wrong priority would drive the bus or start a stray burst. Writes are issued across the doze entry and exit windows, and readback shows exactly which edges were sampled, so an off-by-one in the doze latency shows up as a missing or extra write.

// File: rtl/fbs_pkg.sv
// Shared types and helpers for the flow-through burst SRAM.
// Assumes a burst covers four words selected by the two low address bits.
package fbs_pkg;

    // Kind of access decoded at one clock edge
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_START = 2'd1,
        CYC_NEXT  = 2'd2,
        CYC_HOLD  = 2'd3
    } cyc_e;

    // Low address bits of burst beat k from the starting low bits
    function automatic logic [1:0] seq_lsb(input logic [1:0] base,
                                           input logic [1:0] k,
                                           input logic       linear);
        return linear ? (base + k) : (base ^ k);
    endfunction

endpackage

// File: rtl/fbs_doze.sv
// Doze latency stage: delays the sleep request so that input sampling stops
// LAT edges after it is first seen high and resumes LAT edges after it is
// first seen low. Assumes LAT >= 2.
module fbs_doze #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic doze,
    output logic ignore
);
    logic [LAT-1:0] pipe;

    // Shift the sampled request through LAT stages
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[LAT-2:0], doze};
    end

    assign ignore = pipe[LAT-1];
endmodule

// File: rtl/fbs_decode.sv
// Edge decoder: sorts each clock edge into deselect, burst start, burst step
// or burst hold, and works out the write lane mask. The CPU strobe wins over
// the controller strobe but only while the primary select is active.
// Assumes the inputs are stable around the rising edge.
module fbs_decode
    import fbs_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             sel_hi,
    input  logic             sel_lo_n,
    input  logic             strb_cpu_n,
    input  logic             strb_ctl_n,
    input  logic             step_n,
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic             active,
    input  logic             ignore,
    output cyc_e             cyc,
    output logic             is_wr,
    output logic [LANES-1:0] mask
);
    logic sec_ok;
    logic cpu_seen;

    assign sec_ok   = sel_hi && !sel_lo_n;
    assign cpu_seen = !strb_cpu_n && !sel_n;

    // Lane mask from the global and per-lane write controls
    always_comb begin
        if (ignore)          mask = '0;
        else if (!wr_all_n)  mask = '1;
        else if (!wr_byte_n) mask = ~lane_wr_n;
        else                 mask = '0;
    end

    // Classify the edge by strobe priority and burst state
    always_comb begin
        cyc   = CYC_IDLE;
        is_wr = 1'b0;
        if (ignore) begin
            cyc = CYC_IDLE;
        end else if (cpu_seen) begin
            if (sec_ok) cyc = CYC_START;
        end else if (!strb_ctl_n) begin
            if (!sel_n && sec_ok) begin
                cyc   = CYC_START;
                is_wr = |mask;
            end
        end else if (active) begin
            cyc   = step_n ? CYC_HOLD : CYC_NEXT;
            is_wr = |mask;
        end
    end

    // R4
    cpu_start_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_seen && !ignore) |-> !is_wr);

    // R12
    idle_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && strb_cpu_n && strb_ctl_n) |-> (cyc == CYC_IDLE));
endmodule

// File: rtl/fbs_burst_addr.sv
// Burst address unit: loads the external address when a burst starts, steps
// a two-bit beat counter in linear or interleaved order, and holds the
// address on wait states. A deselect clears the active flag.
// Assumes AW >= 2.
module fbs_burst_addr
    import fbs_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cyc_e          cyc,
    input  logic [AW-1:0] ext_addr,
    input  logic          linear,
    output logic [AW-1:0] acc_addr,
    output logic [AW-1:0] cur_addr,
    output logic          active
);
    logic [1:0] base_lo;
    logic [1:0] beat;
    logic [1:0] beat_nx;

    // Address used by the access at this edge
    always_comb begin
        beat_nx = beat;
        case (cyc)
            CYC_START: begin
                beat_nx  = 2'd0;
                acc_addr = ext_addr;
            end
            CYC_NEXT: begin
                beat_nx  = beat + 2'd1;
                acc_addr = {cur_addr[AW-1:2], seq_lsb(base_lo, beat_nx, linear)};
            end
            default: acc_addr = cur_addr;
        endcase
    end

    // Burst state update per edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_lo  <= '0;
            beat     <= '0;
            cur_addr <= '0;
            active   <= 1'b0;
        end else begin
            case (cyc)
                CYC_START: begin
                    base_lo  <= ext_addr[1:0];
                    beat     <= 2'd0;
                    cur_addr <= ext_addr;
                    active   <= 1'b1;
                end
                CYC_NEXT: begin
                    beat     <= beat_nx;
                    cur_addr <= acc_addr;
                end
                CYC_HOLD: ;
                default:  active <= 1'b0;
            endcase
        end
    end

    // R6
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_START) |=> (cur_addr == $past(ext_addr)));

    // R7
    next_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_NEXT) |=> (beat == $past(beat) + 2'd1) && $stable(cur_addr[AW-1:2]));

    // R8
    hold_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_HOLD) |=> $stable(cur_addr));
endmodule

// File: rtl/fbs_array.sv
// Word storage: one bank per lane, each lane written under its own mask bit
// on the rising edge, read combinationally for the flow-through path.
// Contents are not reset.
module fbs_array #(
    parameter int DEPTH  = 256,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int AW    = $clog2(DEPTH),
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             we,
    input  logic [LANES-1:0] mask,
    input  logic [AW-1:0]    waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [AW-1:0]    raddr,
    output logic [DW-1:0]    rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        // Masked lane write at the edge
        always_ff @(posedge clk) begin
            if (we && mask[g]) bank[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = bank[raddr];
    end
endmodule

// File: rtl/fbs_sram.sv
// Flow-through burst SRAM top: ties together the doze stage, the edge
// decoder, the burst address unit and the lane array. Read data leaves the
// array from the address held since the last edge; the bus is driven only
// after a read edge while output enable is low and doze is low.
module fbs_sram
    import fbs_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    localparam int LANE_W = BYTE_W + 1,
    localparam int DW     = LANES * LANE_W,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             sel_n,
    input  logic             sel_hi,
    input  logic             sel_lo_n,
    input  logic             strb_cpu_n,
    input  logic             strb_ctl_n,
    input  logic             step_n,
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic             out_en_n,
    input  logic             doze,
    input  logic             seq_linear,
    input  logic [DW-1:0]    d_in,
    output logic [DW-1:0]    d_out,
    output logic             d_out_en
);
    logic             ignore;
    cyc_e             cyc;
    logic             is_wr;
    logic [LANES-1:0] mask;
    logic [AW-1:0]    acc_addr;
    logic [AW-1:0]    cur_addr;
    logic             active;
    logic [DW-1:0]    rdata;
    logic             rd_q;

    fbs_doze #(.LAT(2)) u_doze (
        .clk    (clk),
        .rst_n  (rst_n),
        .doze   (doze),
        .ignore (ignore)
    );

    fbs_decode #(.LANES(LANES)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_n      (sel_n),
        .sel_hi     (sel_hi),
        .sel_lo_n   (sel_lo_n),
        .strb_cpu_n (strb_cpu_n),
        .strb_ctl_n (strb_ctl_n),
        .step_n     (step_n),
        .wr_all_n   (wr_all_n),
        .wr_byte_n  (wr_byte_n),
        .lane_wr_n  (lane_wr_n),
        .active     (active),
        .ignore     (ignore),
        .cyc        (cyc),
        .is_wr      (is_wr),
        .mask       (mask)
    );

    fbs_burst_addr #(.AW(AW)) u_bst (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc      (cyc),
        .ext_addr (addr),
        .linear   (seq_linear),
        .acc_addr (acc_addr),
        .cur_addr (cur_addr),
        .active   (active)
    );

    fbs_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk   (clk),
        .we    (is_wr),
        .mask  (mask),
        .waddr (acc_addr),
        .wdata (d_in),
        .raddr (cur_addr),
        .rdata (rdata)
    );

    // Remember whether the last edge was a read access
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= (cyc != CYC_IDLE) && !is_wr;
    end

    assign d_out_en = rd_q && !out_en_n && !doze;
    assign d_out    = d_out_en ? rdata : '0;

    // R10
    wr_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_wr |=> !d_out_en);

    // R11
    doze_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ignore |=> !d_out_en);

    // R10
    zero_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !d_out_en |-> (d_out == '0));
endmodule

// File: tb/fbs_sram_tb.sv
// Scoreboard bench: the driver computes each edge's expected bus state from a
// reference model and queues it; the monitor pops and compares after the edge.
module fbs_sram_tb;
    localparam int DEPTH  = 256;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int DW     = LANES * LANE_W;
    localparam int AW     = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n;
    logic [AW-1:0] addr;
    logic sel_n, sel_hi, sel_lo_n, strb_cpu_n, strb_ctl_n, step_n;
    logic wr_all_n, wr_byte_n, out_en_n, doze, seq_linear;
    logic [LANES-1:0] lane_wr_n;
    logic [DW-1:0] d_in;
    logic [DW-1:0] d_out;
    logic d_out_en;

    always #5 clk = ~clk;

    fbs_sram u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .sel_hi(sel_hi),
        .sel_lo_n(sel_lo_n), .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
        .step_n(step_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
        .lane_wr_n(lane_wr_n), .out_en_n(out_en_n), .doze(doze),
        .seq_linear(seq_linear), .d_in(d_in), .d_out(d_out), .d_out_en(d_out_en)
    );

    typedef struct {
        bit            oe;
        logic [DW-1:0] d;
        string         tag;
    } exp_t;
    exp_t q[$];

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    // Reference model state
    logic [DW-1:0] ref_mem [DEPTH];
    bit            m_act, m_sl1, m_sl2;
    logic [AW-1:0] m_base, m_cur;
    int            m_k;

    function automatic logic [DW-1:0] pat(int a, int salt);
        return DW'((a * 36'h1_3579_BDF1) ^ (salt * 36'h5_A5A5_A5A5) ^ 36'hC_3C3C_3C3C);
    endfunction

    task automatic rest();
        sel_n = 0; sel_hi = 1; sel_lo_n = 0;
        strb_cpu_n = 1; strb_ctl_n = 1; step_n = 1;
        wr_all_n = 1; wr_byte_n = 1; lane_wr_n = '1;
        out_en_n = 0; doze = 0; addr = '0; d_in = '0;
    endtask

    // Driver: model the coming edge, queue the expectation, let the edge pass
    task automatic tick(string tag);
        bit ign, wr, sec;
        int kind;
        logic [LANES-1:0] msk;
        exp_t e;
        ign = m_sl2; m_sl2 = m_sl1; m_sl1 = doze;
        msk = !wr_all_n ? '1 : (!wr_byte_n ? ~lane_wr_n : '0);
        sec = sel_hi && !sel_lo_n;
        wr = 0; kind = 0;
        if (ign) kind = 0;
        else if (!strb_cpu_n && !sel_n) kind = sec ? 1 : 0;
        else if (!strb_ctl_n) begin kind = (!sel_n && sec) ? 1 : 0; wr = (msk != 0); end
        else if (m_act) begin kind = step_n ? 3 : 2; wr = (msk != 0); end
        if (kind == 1) begin m_base = addr; m_k = 0; m_cur = addr; m_act = 1; end
        else if (kind == 2) begin
            logic [1:0] lo;
            m_k = (m_k + 1) % 4;
            lo = seq_linear ? 2'(m_base[1:0] + 2'(m_k)) : (m_base[1:0] ^ 2'(m_k));
            m_cur = {m_base[AW-1:2], lo};
        end else if (kind == 0) m_act = 0;
        if (kind != 0 && wr)
            for (int i = 0; i < LANES; i++)
                if (msk[i]) ref_mem[m_cur][i*LANE_W +: LANE_W] = d_in[i*LANE_W +: LANE_W];
        e.oe  = (kind != 0) && !wr && !out_en_n && !doze;
        e.d   = e.oe ? ref_mem[m_cur] : '0;
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compare the bus shortly after each edge
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (d_out_en !== e.oe || d_out !== e.d) begin
                errs++;
                $display("FAIL %s: oe=%0b d=%h expected oe=%0b d=%h",
                         e.tag, d_out_en, d_out, e.oe, e.d);
            end
        end
    end

    task automatic ctl_start(int a, bit all, bit byt, logic [LANES-1:0] ln, logic [DW-1:0] d, string tag);
        strb_ctl_n = 0; addr = AW'(a); wr_all_n = !all; wr_byte_n = !byt; lane_wr_n = ln; d_in = d;
        tick(tag);
        strb_ctl_n = 1; wr_all_n = 1; wr_byte_n = 1; lane_wr_n = '1;
    endtask

    task automatic cpu_start(int a, string tag);
        strb_cpu_n = 0; addr = AW'(a);
        tick(tag);
        strb_cpu_n = 1;
    endtask

    task automatic step(bit adv, bit wr, logic [DW-1:0] d, string tag);
        step_n = !adv; wr_all_n = !wr; d_in = d;
        tick(tag);
        step_n = 1; wr_all_n = 1;
    endtask

    task automatic desel(string tag);
        sel_n = 1; strb_ctl_n = 0;
        tick(tag);
        sel_n = 0; strb_ctl_n = 1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errs++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        rest(); seq_linear = 1; rst_n = 0;
        m_act = 0; m_sl1 = 0; m_sl2 = 0; m_base = '0; m_cur = '0; m_k = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(posedge clk); #2;
        checks++;
        if (d_out_en !== 1'b0 || d_out !== '0) begin
            errs++;
            $display("FAIL R1: oe=%0b d=%h expected oe=0 d=0", d_out_en, d_out);
        end
        @(negedge clk);
        // R1 / R12: step and hold with no active burst drive nothing
        step(1, 0, '0, "R1");
        step(0, 0, '0, "R12");

        // R6 / R2: fill every word through controller-side global writes
        for (int a = 0; a < DEPTH; a++) ctl_start(a, 1, 0, '1, pat(a, 0), "R6");

        // R4 / R9: CPU-side read, then a hold read
        cpu_start(10, "R9");
        step(0, 0, '0, "R8");
        // R4: CPU start then write on the hold edge
        cpu_start(20, "R4");
        step(0, 1, pat(20, 7), "R4");
        cpu_start(20, "R4");

        // R2: lane write of lanes 0 and 2, parity included
        ctl_start(30, 0, 1, 4'b1010, '1, "R2");
        cpu_start(30, "R2");
        // R3: strobes low but lane enable off -> read, no change
        ctl_start(31, 0, 0, 4'b0000, '0, "R3");
        cpu_start(31, "R3");

        // R7: linear burst from low bits 10, past the fourth beat
        seq_linear = 1;
        cpu_start(42, "R7");
        for (int i = 0; i < 5; i++) step(1, 0, '0, "R7");
        // R7: interleaved burst from low bits 01
        seq_linear = 0;
        cpu_start(45, "R7");
        for (int i = 0; i < 5; i++) step(1, 0, '0, "R7");
        // R8: hold in the middle of a burst
        step(0, 0, '0, "R8");
        step(1, 0, '0, "R7");
        seq_linear = 1;

        // R6 / R8: controller burst write with steps and a held write
        ctl_start(49, 1, 0, '1, pat(49, 3), "R6");
        step(1, 1, pat(50, 3), "R7");
        step(0, 1, pat(51, 3), "R8");
        step(1, 1, pat(52, 3), "R7");
        cpu_start(48, "R7");
        for (int i = 0; i < 3; i++) step(1, 0, '0, "R7");

        // R5: CPU strobe masked by primary select -> burst keeps stepping
        sel_n = 1; strb_cpu_n = 0; step_n = 0;
        tick("R5");
        // R5: masked CPU strobe with controller strobe low -> deselect
        strb_ctl_n = 0; step_n = 1;
        tick("R5");
        strb_ctl_n = 1; strb_cpu_n = 1; sel_n = 0;
        // R5: secondary select off when CPU strobe sampled -> deselect
        sel_lo_n = 1;
        cpu_start(60, "R5");
        sel_lo_n = 0;
        // R12: no burst after deselect
        step(1, 0, '0, "R12");
        step(0, 1, pat(61, 9), "R12");
        cpu_start(61, "R12");
        desel("R12");
        step(1, 0, '0, "R12");

        // R10: output enable high blocks driving
        out_en_n = 1;
        cpu_start(70, "R10");
        out_en_n = 0;
        step(0, 0, '0, "R10");

        // R11: writes across doze entry and exit
        doze = 1;
        for (int i = 0; i < 5; i++) ctl_start(80 + i, 1, 0, '1, pat(80 + i, 5), "R11");
        doze = 0;
        for (int i = 5; i < 9; i++) ctl_start(80 + i, 1, 0, '1, pat(80 + i, 5), "R11");
        for (int i = 0; i < 9; i++) cpu_start(80 + i, "R11");
        cpu_start(83, "R11");
        doze = 1;
        tick("R10");
        doze = 0;
        repeat (2) tick("R11");

        @(posedge clk); #4;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule